// File: doc/BRIEF.md
# Table-Driven Finite State Machine Engine

This block is a general-purpose state machine whose entire behaviour lives in two loadable matrices instead of fixed logic. The transition matrix has one row per state and one column per input symbol, and each cell names the state to enter next. The output matrix either has that same state-by-symbol shape, which gives a Mealy machine, or a single column per state, which gives a Moore machine. A build-time parameter chooses between the two. A second parameter decides whether the output leaves the block straight from the table lookup or through a register.

Software or a sequencer fills both matrices through a small write port while reset is held. It supplies a matrix selector, a row, a column, a data word and a write strobe. When reset is released, the engine steps once per clock. The number of states, the symbol width and the output width are all parameters.

Top module: `tbl_fsm`

## Requirements
- R1: On each rising clock edge with reset low, the state becomes the transition-matrix cell at row = current state and column = `sym_i`, provided that cell is below `NUM_STATES`.
- R2: In Mealy mode (`MEALY`=1) without the output register, `out_o` equals the output-matrix cell at row = current state and column = `sym_i` in the same cycle, with no clock in between.
- R3: In Moore mode (`MEALY`=0) the output matrix has one cell per state. The output depends on the state alone, and `cfg_col` is ignored when that matrix is written.
- R4: With `OUT_REG`=1, `out_o` shows the lookup from the previous clock cycle, delayed by exactly one register.
- R5: A clock edge with `rst` high puts the state to 0 and clears the registered output to 0.
- R6: A write (`cfg_we`=1) is stored only when `rst` is high. A write while running changes neither matrix. `cfg_sel`=0 addresses the transition matrix and `cfg_sel`=1 addresses the output matrix.
- R7: A transition cell holding a value of `NUM_STATES` or more sends the machine to state 0. The state never leaves the range 0 to `NUM_STATES`-1.
- R8: Loaded as a Mealy detector for the overlapping serial pattern 1011, the machine goes from state 3 to state 1 on input 1 and outputs 1 in that cycle.
- R9: Loaded as a Moore detector for 1011, the machine outputs 1 in state 4 and goes from state 4 to state 1 on input 1.
- R10: With `IN_W`=2, all four symbol values select distinct columns of both matrices.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high; also enables matrix writes |
| sym_i | input | IN_W | Current input symbol (column index) |
| cfg_we | input | 1 | Matrix write strobe |
| cfg_sel | input | 1 | 0 = transition matrix, 1 = output matrix |
| cfg_row | input | ST_W | Row (state) of the cell to write |
| cfg_col | input | IN_W | Column (symbol) of the cell to write; unused for the Moore output matrix |
| cfg_data | input | max(ST_W, OUT_W) | Cell value; low ST_W bits for transitions, low OUT_W bits for outputs |
| out_o | output | OUT_W | Machine output |

## Verification
A combinational Mealy output is due in the same cycle the symbol is applied. A registered output is due one rising edge later. A new state shows up through the output in the cycle after the edge that loads it. The bench drives symbols on the falling edge and tags each expected value with the rising-edge count at which it becomes valid. It samples 5 ns after the falling edge, so every comparison happens in the cycle where that result is due, neither earlier nor later. Three instances run side by side on the same symbols: the Mealy and Moore pattern detectors, and a 5-state, 2-bit-symbol machine whose output reveals its state. The third one exercises clamping.

// File: rtl/tbl_fsm_pkg.sv
package tbl_fsm_pkg;
    // Selects which matrix a configuration write targets.
    typedef enum logic {
        TBL_NEXT = 1'b0,
        TBL_OUT  = 1'b1
    } tbl_sel_e;
endpackage

// File: rtl/tbl_fsm_matrix.sv
// Flat row-by-column cell store with synchronous write and combinational read.
// A single-column variant ignores the column inputs.
module tbl_fsm_matrix #(
    parameter int ROWS  = 16,
    parameter int COLS  = 2,
    parameter int ROW_W = 4,
    parameter int COL_W = 1,
    parameter int DW    = 4
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [ROW_W-1:0] wr_row,
    input  logic [COL_W-1:0] wr_col,
    input  logic [DW-1:0]    wr_data,
    input  logic [ROW_W-1:0] rd_row,
    input  logic [COL_W-1:0] rd_col,
    output logic [DW-1:0]    rd_data
);
    localparam int DEPTH = ROWS * COLS;
    localparam int IDX_W = $clog2(DEPTH) + 1;

    logic [IDX_W-1:0] wr_idx;
    logic [IDX_W-1:0] rd_idx;
    logic [DW-1:0]    cells [DEPTH];

    generate
        if (COLS == 1) begin : g_single
            logic unused_cols;
            assign unused_cols = ^{wr_col, rd_col};
            assign wr_idx = IDX_W'(wr_row);
            assign rd_idx = IDX_W'(rd_row);
        end else begin : g_grid
            assign wr_idx = IDX_W'(wr_row) * IDX_W'(COLS) + IDX_W'(wr_col);
            assign rd_idx = IDX_W'(rd_row) * IDX_W'(COLS) + IDX_W'(rd_col);
        end
    endgenerate

    // Rows beyond ROWS produce an index past DEPTH and match no cell.
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (wr_en && (wr_idx == IDX_W'(i))) begin
                cells[i] <= wr_data;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (rd_idx == IDX_W'(i)) begin
                rd_data = cells[i];
            end
        end
    end
endmodule

// File: rtl/tbl_fsm_clamp.sv
// Folds any out-of-range target state back to state 0.
module tbl_fsm_clamp #(
    parameter int NUM_STATES = 16,
    parameter int ST_W       = 4
) (
    input  logic [ST_W-1:0] raw,
    output logic [ST_W-1:0] safe
);
    logic beyond;
    assign beyond = {1'b0, raw} >= (ST_W+1)'(NUM_STATES);
    assign safe   = beyond ? '0 : raw;
endmodule

// File: rtl/tbl_fsm.sv
module tbl_fsm
    import tbl_fsm_pkg::*;
#(
    parameter int  NUM_STATES = 16,
    parameter int  IN_W       = 1,
    parameter int  OUT_W      = 1,
    parameter bit  MEALY      = 1'b1,
    parameter bit  OUT_REG    = 1'b0,
    localparam int ST_W       = (NUM_STATES > 2) ? $clog2(NUM_STATES) : 1,
    localparam int CFG_W      = (ST_W > OUT_W) ? ST_W : OUT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IN_W-1:0]   sym_i,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [ST_W-1:0]   cfg_row,
    input  logic [IN_W-1:0]   cfg_col,
    input  logic [CFG_W-1:0]  cfg_data,
    output logic [OUT_W-1:0]  out_o
);
    localparam int NUM_SYM = 1 << IN_W;
    localparam int OCOLS   = MEALY ? NUM_SYM : 1;

    typedef struct packed {
        logic [ST_W-1:0]  state;
        logic [OUT_W-1:0] out;
    } regs_t;

    regs_t            cur_q, nxt_d;
    logic [ST_W-1:0]  state_q;
    logic [ST_W-1:0]  ns_raw;
    logic [ST_W-1:0]  ns_safe;
    logic [OUT_W-1:0] look;
    tbl_sel_e         sel;
    logic             wr_next;
    logic             wr_outp;

    assign sel     = tbl_sel_e'(cfg_sel);
    assign wr_next = cfg_we & rst & (sel == TBL_NEXT);
    assign wr_outp = cfg_we & rst & (sel == TBL_OUT);
    assign state_q = cur_q.state;

    tbl_fsm_matrix #(
        .ROWS (NUM_STATES), .COLS (NUM_SYM), .ROW_W (ST_W), .COL_W (IN_W), .DW (ST_W)
    ) u_next (
        .clk     (clk),
        .wr_en   (wr_next),
        .wr_row  (cfg_row),
        .wr_col  (cfg_col),
        .wr_data (cfg_data[ST_W-1:0]),
        .rd_row  (state_q),
        .rd_col  (sym_i),
        .rd_data (ns_raw)
    );

    tbl_fsm_matrix #(
        .ROWS (NUM_STATES), .COLS (OCOLS), .ROW_W (ST_W), .COL_W (IN_W), .DW (OUT_W)
    ) u_outp (
        .clk     (clk),
        .wr_en   (wr_outp),
        .wr_row  (cfg_row),
        .wr_col  (cfg_col),
        .wr_data (cfg_data[OUT_W-1:0]),
        .rd_row  (state_q),
        .rd_col  (sym_i),
        .rd_data (look)
    );

    tbl_fsm_clamp #(
        .NUM_STATES (NUM_STATES), .ST_W (ST_W)
    ) u_clamp (
        .raw  (ns_raw),
        .safe (ns_safe)
    );

    always_comb begin
        nxt_d       = cur_q;
        nxt_d.state = ns_safe;
        nxt_d.out   = OUT_REG ? look : '0;
        if (rst) begin
            nxt_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        cur_q <= nxt_d;
    end

    generate
        if (OUT_REG) begin : g_reg_out
            assign out_o = cur_q.out;
        end else begin : g_comb_out
            logic unused_outq;
            assign unused_outq = ^cur_q.out;
            assign out_o = look;
        end
    endgenerate
endmodule

// File: rtl/tbl_fsm_chk.sv
module tbl_fsm_chk #(
    parameter int NUM_STATES = 16,
    parameter int ST_W       = 4,
    parameter int OUT_W      = 1,
    parameter bit OUT_REG    = 1'b0
) (
    input logic             clk,
    input logic             rst,
    input logic [ST_W-1:0]  state_q,
    input logic [ST_W-1:0]  ns_raw,
    input logic [OUT_W-1:0] look,
    input logic [OUT_W-1:0] out_o
);
    localparam logic [ST_W:0] LIM = (ST_W+1)'(NUM_STATES);

    p_range_r7: assert property (@(posedge clk) disable iff (rst)
        {1'b0, state_q} < LIM);

    p_step_r1: assert property (@(posedge clk) disable iff (rst)
        (!rst && ({1'b0, ns_raw} < LIM)) |=> (state_q == $past(ns_raw)));

    p_clamp_r7: assert property (@(posedge clk) disable iff (rst)
        (!rst && ({1'b0, ns_raw} >= LIM)) |=> (state_q == '0));

    p_reset_state_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (state_q == '0));

    generate
        if (OUT_REG) begin : g_reg_checks
            p_reset_out_r5: assert property (@(posedge clk) disable iff (rst)
                $fell(rst) |-> (out_o == '0));

            p_out_delay_r4: assert property (@(posedge clk) disable iff (rst)
                !rst |=> (out_o == $past(look)));
        end
    endgenerate
endmodule

bind tbl_fsm tbl_fsm_chk #(
    .NUM_STATES (NUM_STATES),
    .ST_W       (ST_W),
    .OUT_W      (OUT_W),
    .OUT_REG    (OUT_REG)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .state_q (state_q),
    .ns_raw  (ns_raw),
    .look    (look),
    .out_o   (out_o)
);

// File: tb/tbl_fsm_test.sv
module tbl_fsm_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] sym = 2'd0;
    logic       cfg_sel = 1'b0;
    logic [3:0] cfg_row = 4'd0;
    logic [1:0] cfg_col = 2'd0;
    logic [3:0] cfg_data = 4'd0;
    logic       we_a = 1'b0, we_b = 1'b0, we_c = 1'b0;
    logic       out_a, out_b;
    logic [2:0] out_c;

    int checks = 0;
    int fails  = 0;
    int pcnt   = 0;
    int ms_a = 0, ms_b = 0, ms_c = 0;

    typedef struct {
        int         due;
        logic [2:0] val;
        string      tag;
    } item_t;
    item_t qa[$], qb[$], qc[$];

    always #10 clk = ~clk;  // 50 MHz
    always @(posedge clk) pcnt <= pcnt + 1;

    // Mealy 1011 detector, 16-state capacity, combinational output
    tbl_fsm #(.NUM_STATES(16), .IN_W(1), .OUT_W(1), .MEALY(1'b1), .OUT_REG(1'b0)) uut (
        .clk(clk), .rst(rst), .sym_i(sym[0]), .cfg_we(we_a), .cfg_sel(cfg_sel),
        .cfg_row(cfg_row), .cfg_col(cfg_col[0]), .cfg_data(cfg_data), .out_o(out_a));

    // Moore 1011 detector, registered output
    tbl_fsm #(.NUM_STATES(8), .IN_W(1), .OUT_W(1), .MEALY(1'b0), .OUT_REG(1'b1)) u_moore (
        .clk(clk), .rst(rst), .sym_i(sym[0]), .cfg_we(we_b), .cfg_sel(cfg_sel),
        .cfg_row(cfg_row[2:0]), .cfg_col(cfg_col[0]), .cfg_data(cfg_data[2:0]), .out_o(out_b));

    // 5 states, 2-bit symbols, output = state, some cells out of range
    tbl_fsm #(.NUM_STATES(5), .IN_W(2), .OUT_W(3), .MEALY(1'b1), .OUT_REG(1'b0)) u_clamp (
        .clk(clk), .rst(rst), .sym_i(sym), .cfg_we(we_c), .cfg_sel(cfg_sel),
        .cfg_row(cfg_row[2:0]), .cfg_col(cfg_col), .cfg_data(cfg_data[2:0]), .out_o(out_c));

    function automatic int mealy_ns(int s, int b);
        case (s)
            0: return b ? 1 : 0;
            1: return b ? 1 : 2;
            2: return b ? 3 : 0;
            default: return b ? 1 : 2;
        endcase
    endfunction
    function automatic int mealy_out(int s, int b);
        return (s == 3 && b == 1) ? 1 : 0;
    endfunction
    function automatic int moore_ns(int s, int b);
        case (s)
            0: return b ? 1 : 0;
            1: return b ? 1 : 2;
            2: return b ? 3 : 0;
            3: return b ? 4 : 2;
            default: return b ? 1 : 2;
        endcase
    endfunction
    function automatic int moore_out(int s);
        return (s == 4) ? 1 : 0;
    endfunction
    // Raw cell contents of the clamp machine (3-bit cells).
    function automatic int clamp_raw(int s, int v);
        case (v)
            0: return s;
            1: return s + 1;
            2: return 7;
            default: return 4;
        endcase
    endfunction
    function automatic int clamp_ns(int s, int v);
        int r = clamp_raw(s, v);
        return (r >= 5) ? 0 : r;
    endfunction

    task automatic cfg_write(int which, bit sel, int row, int col, int data);
        @(negedge clk);
        cfg_sel  = sel;
        cfg_row  = row[3:0];
        cfg_col  = col[1:0];
        cfg_data = data[3:0];
        we_a = (which == 0);
        we_b = (which == 1);
        we_c = (which == 2);
        @(negedge clk);
        we_a = 1'b0; we_b = 1'b0; we_c = 1'b0;
    endtask

    // Driver: applies one symbol for one cycle and pushes expected results.
    task automatic step(logic [1:0] v, logic r, string tag);
        @(negedge clk);
        sym = v;
        rst = r;
        qa.push_back('{pcnt, 3'(mealy_out(ms_a, int'(v[0]))), tag});
        qb.push_back('{pcnt + 1, r ? 3'd0 : 3'(moore_out(ms_b)), tag});
        qc.push_back('{pcnt, 3'(ms_c), tag});
        ms_a = r ? 0 : mealy_ns(ms_a, int'(v[0]));
        ms_b = r ? 0 : moore_ns(ms_b, int'(v[0]));
        ms_c = r ? 0 : clamp_ns(ms_c, int'(v));
    endtask

    task automatic sb_pop(ref item_t q[$], input logic [2:0] act, input string who);
        item_t it;
        while (q.size() > 0 && q[0].due <= pcnt) begin
            it = q.pop_front();
            checks++;
            if (it.due != pcnt || act !== it.val) begin
                fails++;
                $display("FAIL %s %s: got %0d expected %0d (due %0d at %0d)",
                         it.tag, who, act, it.val, it.due, pcnt);
            end
        end
    endtask

    // Monitor: samples 5 ns after each falling edge.
    always @(negedge clk) begin
        #5;
        sb_pop(qa, {2'b00, out_a}, "mealy");
        sb_pop(qb, {2'b00, out_b}, "moore");
        sb_pop(qc, out_c, "clamp");
    end

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        // Load under reset (R6). Moore outputs written with col=1 (R3).
        for (int s = 0; s < 4; s++) begin
            for (int b = 0; b < 2; b++) begin
                cfg_write(0, 1'b0, s, b, mealy_ns(s, b));
                cfg_write(0, 1'b1, s, b, mealy_out(s, b));
            end
        end
        for (int s = 0; s < 5; s++) begin
            for (int b = 0; b < 2; b++) cfg_write(1, 1'b0, s, b, moore_ns(s, b));
            cfg_write(1, 1'b1, s, 1, moore_out(s));
        end
        for (int s = 0; s < 5; s++) begin
            for (int v = 0; v < 4; v++) begin   // R10: four distinct columns
                cfg_write(2, 1'b0, s, v, clamp_raw(s, v));
                cfg_write(2, 1'b1, s, v, s);
            end
        end

        // R5: reset state and cleared registered output
        for (int i = 0; i < 3; i++) step(2'(i + 1), 1'b1, "R5 reset");

        // R8: Mealy 1011, state 3 input 1 -> output 1
        step(2'd1, 1'b0, "R8");
        step(2'd0, 1'b0, "R8");
        step(2'd1, 1'b0, "R8");
        step(2'd1, 1'b0, "R8 hit");

        // R1 R2 R4 R7 R10: random symbol streams
        for (int i = 0; i < 600; i++) begin
            step(2'($urandom_range(0, 3)), 1'b0, "R1 R2 R4 R7 R10 random");
        end

        // R7: clamp directed, 4 --sym1--> 5 clamped to 0
        step(2'd3, 1'b0, "R7");
        step(2'd1, 1'b0, "R7");
        step(2'd2, 1'b0, "R7");

        // R9: Moore 1011, output 1 in state 4, then state 1 on input 1
        step(2'd0, 1'b0, "R9");
        step(2'd0, 1'b0, "R9");
        step(2'd1, 1'b0, "R9");
        step(2'd0, 1'b0, "R9");
        step(2'd1, 1'b0, "R9");
        step(2'd1, 1'b0, "R9 hit");
        step(2'd1, 1'b0, "R9 exit");
        step(2'd0, 1'b0, "R9");

        // R6: writes while running must be ignored
        cfg_sel  = 1'b1;
        cfg_row  = 4'd0;
        cfg_col  = 2'd0;
        cfg_data = 4'd1;
        we_a = 1'b1;
        we_c = 1'b1;
        step(2'd0, 1'b0, "R6");
        step(2'd0, 1'b0, "R6");
        cfg_sel  = 1'b0;
        cfg_data = 4'd3;
        step(2'd0, 1'b0, "R6");
        we_a = 1'b0;
        we_c = 1'b0;
        for (int i = 0; i < 6; i++) step(2'd0, 1'b0, "R6 after");
        step(2'd1, 1'b0, "R6 after");
        step(2'd0, 1'b0, "R6 after");

        // R5: reset in mid-run
        step(2'd1, 1'b0, "R5");
        step(2'd1, 1'b1, "R5 reset");
        step(2'd3, 1'b1, "R5 reset");
        step(2'd1, 1'b0, "R5 release");
        step(2'd0, 1'b0, "R5 release");

        repeat (3) @(negedge clk);
        #8;
        if (qa.size() + qb.size() + qc.size() != 0) begin
            checks++;
            fails++;
            $display("FAIL scoreboard: got %0d pending expected 0",
                     qa.size() + qb.size() + qc.size());
        end
        finish_run();
    end
endmodule